// File: doc/BRIEF.md
# Dual-Input Up/Down Counter with Carry and Borrow

This block is a presettable binary counter that is stepped by two separate count inputs. A rising edge on the up input adds one, and a rising edge on the down input subtracts one. The direction therefore comes from which input pulses, and no direction pin is used. Both count inputs are asynchronous to the block. A free-running system clock samples them through synchronizers, and edge detectors find their rising edges.

An active-high clear forces the count to zero. An active-low load copies the data bus into the count. Neither of them waits for a count edge. Clear wins over load, and load wins over counting.

Two active-low terminal outputs are gated copies of the count inputs:
- The carry output copies the up input while the count is at its maximum.
- The borrow output copies the down input while the count is zero.

Because these outputs follow the waveform of the count inputs, they can drive the count inputs of a following stage.

Top module: `udc_dual_clk_counter`

## Requirements
- R1: A rising edge on `up_in` increments `q` by one if `dn_in` is high at that time. The new value appears on `q` by the fourth system-clock falling edge after the input edge.
- R2: A rising edge on `dn_in` decrements `q` by one if `up_in` is high at that time. The same latency as R1 applies.
- R3: While `clr` is high, `q` is 0. This holds even if `load_n` is low or either count input toggles, and `q` remains 0 after `clr` is released.
- R4: While `load_n` is low and `clr` is low, `q` follows `din`. Activity on the count inputs is ignored during this time.
- R5: `carry_n` is low only while `q` is all ones and `up_in` is low. Otherwise it is high, and it returns high when `up_in` rises.
- R6: `borrow_n` is low only while `q` is 0 and `dn_in` is low. Otherwise it is high.
- R7: A count input can be low during a clear or load and stay low after the release. Its first rising edge after the release is counted.
- R8: Counting up from all ones gives 0, and counting down from 0 gives all ones.
- R9: In two cases `q` is left unchanged:
  - both count inputs rise in the same sampling cycle;
  - one count input rises while the other is low.
- R10: After `arst_n` is released, `q` is 0 and both terminal outputs are high while both count inputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock that samples all control inputs |
| arst_n | input | 1 | Asynchronous system reset, active low |
| clr | input | 1 | Master clear, active high, asynchronous to clk |
| load_n | input | 1 | Parallel load, active low, asynchronous to clk |
| din | input | WIDTH | Preset value copied into the count during load |
| up_in | input | 1 | Count-up input, rising-edge active |
| dn_in | input | 1 | Count-down input, rising-edge active |
| q | output | WIDTH | Current count |
| carry_n | output | 1 | Terminal count up, active low |
| borrow_n | output | 1 | Terminal count down, active low |

## Verification
Single pulses on each count input with the other input held high show the two step directions. They also show the wrap at each end of the range, and that the carry and borrow outputs copy the low phase of the proper input only at the terminal states.

Three patterns must leave the count alone:
- both inputs rising together;
- the up input pulsing while the down input is low;
- the up input pulsing during a clear.

These separate a design that really gates on the other input's level from one that only looks at edges.

In a further test, a count input is held low through a load or a clear and released afterwards. This shows that the edge following the release is counted rather than lost. A final test drives clear and load at the same time, which confirms that clear has priority.

// File: rtl/udc_pkg.sv
package udc_pkg;
   typedef enum logic [2:0] {
      OP_HOLD  = 3'd0,
      OP_INC   = 3'd1,
      OP_DEC   = 3'd2,
      OP_LOAD  = 3'd3,
      OP_CLEAR = 3'd4
   } udc_op_e;
endpackage

// File: rtl/udc_sync.sv
module udc_sync #(
   parameter int          NBITS   = 4,
   parameter int          STAGES  = 2,
   parameter logic [NBITS-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic [NBITS-1:0] d_async,
   output logic [NBITS-1:0] d_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("udc_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < NBITS; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) begin
            chain <= {STAGES{RST_VAL[b]}};
         end else begin
            chain <= {chain[STAGES-2:0], d_async[b]};
         end
      end
      assign d_sync[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/udc_edge.sv
module udc_edge #(
   parameter int NBITS = 2
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic [NBITS-1:0] lvl,
   output logic [NBITS-1:0] rise
);
   logic [NBITS-1:0] prev;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         prev <= '1;
      end else begin
         prev <= lvl;
      end
   end

   for (genvar b = 0; b < NBITS; b++) begin : g_rise
      assign rise[b] = lvl[b] & ~prev[b];
   end
endmodule

// File: rtl/udc_decode.sv
module udc_decode
   import udc_pkg::*;
(
   input  logic    clr_lvl,
   input  logic    load_n_lvl,
   input  logic    up_lvl,
   input  logic    dn_lvl,
   input  logic    up_rise,
   input  logic    dn_rise,
   output udc_op_e op
);
   logic up_ok;
   logic dn_ok;

   assign up_ok = up_rise & ~dn_rise & dn_lvl;
   assign dn_ok = dn_rise & ~up_rise & up_lvl;

   always_comb begin
      if (clr_lvl) begin
         op = OP_CLEAR;
      end else if (!load_n_lvl) begin
         op = OP_LOAD;
      end else if (up_ok) begin
         op = OP_INC;
      end else if (dn_ok) begin
         op = OP_DEC;
      end else begin
         op = OP_HOLD;
      end
   end
endmodule

// File: rtl/udc_core.sv
module udc_core
   import udc_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             arst_n,
   input  udc_op_e          op,
   input  logic [WIDTH-1:0] din,
   input  logic             up_lvl,
   input  logic             dn_lvl,
   output logic [WIDTH-1:0] q,
   output logic             carry_n,
   output logic             borrow_n
);
   localparam logic [WIDTH-1:0] CNT_MAX  = '1;
   localparam logic [WIDTH-1:0] CNT_ZERO = '0;
   localparam logic [WIDTH-1:0] CNT_ONE  = WIDTH'(1);

   logic [WIDTH-1:0] cnt_q;
   logic [WIDTH-1:0] cnt_d;

   always_comb begin
      unique case (op)
         OP_CLEAR: cnt_d = CNT_ZERO;
         OP_LOAD:  cnt_d = din;
         OP_INC:   cnt_d = cnt_q + CNT_ONE;
         OP_DEC:   cnt_d = cnt_q - CNT_ONE;
         default:  cnt_d = cnt_q;
      endcase
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cnt_q <= CNT_ZERO;
      end else begin
         cnt_q <= cnt_d;
      end
   end

   assign q        = cnt_q;
   assign carry_n  = ~((cnt_q == CNT_MAX) & ~up_lvl);
   assign borrow_n = ~((cnt_q == CNT_ZERO) & ~dn_lvl);
endmodule

// File: rtl/udc_dual_clk_counter.sv
module udc_dual_clk_counter
   import udc_pkg::*;
#(
   parameter int WIDTH       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             clr,
   input  logic             load_n,
   input  logic [WIDTH-1:0] din,
   input  logic             up_in,
   input  logic             dn_in,
   output logic [WIDTH-1:0] q,
   output logic             carry_n,
   output logic             borrow_n
);
   localparam int NCTL = 4;
   localparam logic [NCTL-1:0] CTL_RST = 4'b1111;

   if (WIDTH < 1) begin : g_bad_width
      $error("udc_dual_clk_counter: WIDTH must be at least 1");
   end

   logic [NCTL-1:0] ctl_raw;
   logic [NCTL-1:0] ctl_lvl;
   logic            clr_lvl;
   logic            load_n_lvl;
   logic            up_lvl;
   logic            dn_lvl;
   logic [1:0]      rise;
   udc_op_e         op;

   assign ctl_raw = {clr, load_n, up_in, dn_in};

   udc_sync #(
      .NBITS  (NCTL),
      .STAGES (SYNC_STAGES),
      .RST_VAL(CTL_RST)
   ) u_sync (
      .clk    (clk),
      .arst_n (arst_n),
      .d_async(ctl_raw),
      .d_sync (ctl_lvl)
   );

   assign {clr_lvl, load_n_lvl, up_lvl, dn_lvl} = ctl_lvl;

   udc_edge #(.NBITS(2)) u_edge (
      .clk   (clk),
      .arst_n(arst_n),
      .lvl   ({up_lvl, dn_lvl}),
      .rise  (rise)
   );

   udc_decode u_dec (
      .clr_lvl   (clr_lvl),
      .load_n_lvl(load_n_lvl),
      .up_lvl    (up_lvl),
      .dn_lvl    (dn_lvl),
      .up_rise   (rise[1]),
      .dn_rise   (rise[0]),
      .op        (op)
   );

   udc_core #(.WIDTH(WIDTH)) u_core (
      .clk     (clk),
      .arst_n  (arst_n),
      .op      (op),
      .din     (din),
      .up_lvl  (up_lvl),
      .dn_lvl  (dn_lvl),
      .q       (q),
      .carry_n (carry_n),
      .borrow_n(borrow_n)
   );
endmodule

// File: rtl/udc_dual_clk_counter_chk.sv
module udc_dual_clk_counter_chk
   import udc_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input logic             clk,
   input logic             arst_n,
   input logic             clr_lvl,
   input logic             up_lvl,
   input logic             dn_lvl,
   input logic [1:0]       rise,
   input udc_op_e          op,
   input logic [WIDTH-1:0] din,
   input logic [WIDTH-1:0] q,
   input logic             carry_n,
   input logic             borrow_n
);
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!arst_n)
      clr_lvl |=> (q == '0)); // R3
   AST_LOAD_FOLLOWS: assert property (@(posedge clk) disable iff (!arst_n)
      (op == OP_LOAD) |=> (q == $past(din))); // R4
   AST_UP_STEP: assert property (@(posedge clk) disable iff (!arst_n)
      (!clr_lvl && op != OP_LOAD && rise == 2'b10 && dn_lvl) |=> (q == $past(q) + ONE)); // R1
   AST_DN_STEP: assert property (@(posedge clk) disable iff (!arst_n)
      (!clr_lvl && op != OP_LOAD && rise == 2'b01 && up_lvl) |=> (q == $past(q) - ONE)); // R2
   AST_NO_STEP: assert property (@(posedge clk) disable iff (!arst_n)
      (op != OP_LOAD && op != OP_CLEAR && (rise == 2'b11 || (rise[1] && !dn_lvl))) |=> $stable(q)); // R9
   AST_CARRY_TERM: assert property (@(posedge clk) disable iff (!arst_n)
      !carry_n |-> (q == '1 && !up_lvl)); // R5
   AST_BORROW_TERM: assert property (@(posedge clk) disable iff (!arst_n)
      !borrow_n |-> (q == '0 && !dn_lvl)); // R6
endmodule

bind udc_dual_clk_counter udc_dual_clk_counter_chk #(.WIDTH(WIDTH)) u_chk (
   .clk     (clk),
   .arst_n  (arst_n),
   .clr_lvl (clr_lvl),
   .up_lvl  (up_lvl),
   .dn_lvl  (dn_lvl),
   .rise    (rise),
   .op      (op),
   .din     (din),
   .q       (q),
   .carry_n (carry_n),
   .borrow_n(borrow_n)
);

// File: tb/udc_dual_clk_counter_bench.sv
`timescale 1ns/1ps
module udc_dual_clk_counter_bench;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         arst_n = 1'b0;
   logic         clr = 1'b0;
   logic         load_n = 1'b1;
   logic [W-1:0] din = '0;
   logic         up_in = 1'b1;
   logic         dn_in = 1'b1;
   logic [W-1:0] q;
   logic         carry_n;
   logic         borrow_n;

   int  n_checks = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   udc_dual_clk_counter #(.WIDTH(W), .SYNC_STAGES(2)) u_udc_dual_clk_counter (
      .clk(clk), .arst_n(arst_n), .clr(clr), .load_n(load_n), .din(din),
      .up_in(up_in), .dn_in(dn_in), .q(q), .carry_n(carry_n), .borrow_n(borrow_n)
   );

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic pulse_up();
      up_in = 1'b0; wait_n(4);
      up_in = 1'b1; wait_n(4);
   endtask

   task automatic pulse_dn();
      dn_in = 1'b0; wait_n(4);
      dn_in = 1'b1; wait_n(4);
   endtask

   task automatic t_reset();
      wait_n(3); arst_n = 1'b1; wait_n(4);
      check("R10 q", q, 0);
      check("R10 carry_n", carry_n, 1);
      check("R10 borrow_n", borrow_n, 1);
   endtask

   task automatic t_load();
      din = 4'hE; load_n = 1'b0; wait_n(4);
      check("R4 load", q, 14);
      din = 4'h3; pulse_up();
      check("R4 follow, count ignored", q, 3);
      din = 4'hD; wait_n(4);
      load_n = 1'b1; wait_n(4);
      check("R4 release", q, 13);
   endtask

   task automatic t_up_carry();
      pulse_up();
      check("R1 up", q, 14);
      pulse_up();
      check("R1 up to max", q, 15);
      check("R5 carry idle", carry_n, 1);
      up_in = 1'b0; wait_n(3);
      check("R5 carry low", carry_n, 0);
      up_in = 1'b1; wait_n(4);
      check("R8 wrap up", q, 0);
      check("R5 carry high again", carry_n, 1);
   endtask

   task automatic t_dn_borrow();
      dn_in = 1'b0; wait_n(3);
      check("R6 borrow low", borrow_n, 0);
      check("R5 carry stays high", carry_n, 1);
      dn_in = 1'b1; wait_n(4);
      check("R8 wrap down", q, 15);
      check("R6 borrow high", borrow_n, 1);
      pulse_dn();
      check("R2 down", q, 14);
   endtask

   task automatic t_conflict();
      up_in = 1'b0; dn_in = 1'b0; wait_n(4);
      up_in = 1'b1; dn_in = 1'b1; wait_n(4);
      check("R9 both rise", q, 14);
      dn_in = 1'b0; wait_n(4);
      pulse_up();
      check("R9 up while dn low", q, 14);
      dn_in = 1'b1; wait_n(4);
      check("R2 dn with up high", q, 13);
   endtask

   task automatic t_pending();
      up_in = 1'b0; din = 4'h5; load_n = 1'b0; wait_n(4);
      load_n = 1'b1; wait_n(4);
      up_in = 1'b1; wait_n(4);
      check("R7 edge after load", q, 6);
      dn_in = 1'b0; clr = 1'b1; wait_n(4);
      check("R3 clear", q, 0);
      clr = 1'b0; wait_n(4);
      dn_in = 1'b1; wait_n(4);
      check("R7 edge after clear", q, 15);
   endtask

   task automatic t_clear_prio();
      clr = 1'b1; din = 4'h9; load_n = 1'b0; wait_n(4);
      check("R3 over load", q, 0);
      pulse_up();
      check("R3 over count", q, 0);
      clr = 1'b0; load_n = 1'b1; wait_n(4);
      check("R3 after release", q, 0);
   endtask

   initial begin
      t_reset();
      t_load();
      t_up_carry();
      t_dn_borrow();
      t_conflict();
      t_pending();
      t_clear_prio();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got 0 expected 1");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule